// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column addresses of one SDRAM read or write burst, one address per clock. A mode load stores a 4-bit setting that holds a burst length code and an ordering flag. A later start pulse gives the first column. From the next clock onward the block drives one column per cycle in sequential or interleaved order. It raises a last flag on the final beat of a burst of fixed length.

A full-page setting keeps a sequential burst running through the whole page. At the page end the column wraps back to 0, and the burst runs until it is stopped. A stop input ends any burst. A new start pulse replaces a burst that is still running. The parameter `X16_ORG` sets the column width: 8 bits (a 256-column page) when it is 1, and 9 bits (a 512-column page) when it is 0.

Top module: `burst_col_seq`

## Requirements
- R1: On a clock edge where `mode_load` is high, the block stores `mode_bits`. Bit 3 selects the order (0 = sequential, 1 = interleaved). Bits 2:0 select the length: 000 = 1 beat, 001 = 2, 010 = 4, 011 = 8, 111 = full page. A burst uses the setting stored before the edge on which it starts.
- R2: In sequential order, the low k column bits (k = 1, 2, 3 for lengths 2, 4, 8) count up from the start value and wrap inside the aligned block. For example, length 8 from start low bits 5 gives 5,6,7,0,1,2,3,4.
- R3: In interleaved order, the low k bits of beat i equal the start low bits XOR i. For example, length 8 from 5 gives 5,4,7,6,1,0,3,2.
- R4: Column bits above the low k bits stay equal to the start column for the whole burst.
- R5: `col_valid` is high for exactly the burst length in beats. `col_last` is high only on the final beat of a burst that is not full page. It is never high without `col_valid`.
- R6: A full-page burst increments the column by 1 each beat, wraps from the top column of the page to 0, never raises `col_last`, and does not end by itself.
- R7: Loading full page together with interleaved order runs bursts in sequential order and sets `mode_err`. `mode_err` stays high until reset.
- R8: The reserved length codes (100, 101, 110) act as length 1.
- R9: If `stop` is high on an edge during a burst and `start` is low, `col_valid` is low after that edge.
- R10: A start pulse during a burst abandons the running burst. The next beat is the new start column, and the full new length follows.
- R11: After reset, and whenever no burst runs, `col_valid`, `col_last` and `col_out` are 0. After reset `mode_err` is 0.
- R12: The first beat appears on the clock after the start edge, with `col_out` equal to the start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Store `mode_bits` on this edge |
| mode_bits | input | 4 | Order flag (bit 3) and length code (bits 2:0) |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | COL_W | First column of the burst (8 bits by default) |
| stop | input | 1 | End the running burst |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is present |
| col_last | output | 1 | Final beat of a burst of fixed length |
| mode_err | output | 1 | Sticky flag: full page was requested with interleaved order |

## Verification
The bound checker tests, on every cycle, the rules that relate nearby cycles. It checks that the first beat follows a start and carries the start column. It checks that a burst ends after a stop or after its last beat, that the last flag never appears without valid, that the error flag stays high, and that the idle outputs are zero. Only the bench's scenarios can show the column orders themselves: the wrap in sequential order, the XOR pattern in interleaved order, and the fixed upper bits. They also show the beat count for each length, the fall-back for reserved codes, the wrap at the page end in full page, and a restart in the middle of a burst.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
   // Length field codes held in mode bits 2:0
   typedef enum logic [2:0] {
      LEN_1    = 3'b000,
      LEN_2    = 3'b001,
      LEN_4    = 3'b010,
      LEN_8    = 3'b011,
      LEN_PAGE = 3'b111
   } len_code_e;

   // Decoded burst shape
   typedef struct packed {
      logic full;  // full-page burst
      logic ilv;   // interleaved ordering
      logic bad;   // full page with interleaved was requested
   } burst_kind_t;
endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
   import burst_col_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [3:0]       mode_bits,
   output logic [COL_W-1:0] span_mask,
   output burst_kind_t      kind
);
   len_code_e code;

   always_comb begin
      code      = len_code_e'(mode_bits[2:0]);
      span_mask = '0;
      kind      = '0;
      case (code)
         LEN_2:    span_mask = COL_W'(1);
         LEN_4:    span_mask = COL_W'(3);
         LEN_8:    span_mask = COL_W'(7);
         LEN_PAGE: begin
            span_mask = '1;
            kind.full = 1'b1;
         end
         default:  span_mask = '0;   // length 1, reserved codes included
      endcase
      // Full page always runs in sequential order
      kind.ilv = mode_bits[3] & ~kind.full;
      kind.bad = mode_bits[3] &  kind.full;
   end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
   parameter int COL_W = 8
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] beat,
   input  logic [COL_W-1:0] span_mask,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] seq_sum;

   // A carry out of the masked bits never reaches back into them, so the
   // low bits of the sum wrap inside the aligned block.
   assign seq_sum = base + beat;

   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      assign col[b] = span_mask[b] ? (ilv ? (base[b] ^ beat[b]) : seq_sum[b])
                                   : base[b];
   end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import burst_col_pkg::*;
#(
   parameter bit X16_ORG = 1'b1,
   parameter int COL_W   = X16_ORG ? 8 : 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_load,
   input  logic [3:0]       mode_bits,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic             stop,
   output logic [COL_W-1:0] col_out,
   output logic             col_valid,
   output logic             col_last,
   output logic             mode_err
);
   localparam int PAGE_COLS = 1 << COL_W;

   if (COL_W != (X16_ORG ? 8 : 9)) begin : g_bad_width
      $error("burst_col_seq: COL_W does not match the organization");
   end
   if (PAGE_COLS < 8) begin : g_bad_page
      $error("burst_col_seq: page shorter than the longest fixed burst");
   end

   logic [COL_W-1:0] dec_mask;
   burst_kind_t      dec_kind;

   logic [COL_W-1:0] mode_mask_q;
   burst_kind_t      mode_kind_q;
   logic             err_q;

   logic             run_q;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] beat_q;
   logic [COL_W-1:0] mask_q;
   logic             full_q;
   logic             ilv_q;

   logic [COL_W-1:0] gen_col;
   logic             at_end;

   burst_mode_dec #(.COL_W(COL_W)) u_dec (
      .mode_bits (mode_bits),
      .span_mask (dec_mask),
      .kind      (dec_kind)
   );

   // Mode storage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_mask_q <= '0;
         mode_kind_q <= '0;
         err_q       <= 1'b0;
      end else if (mode_load) begin
         mode_mask_q <= dec_mask;
         mode_kind_q <= dec_kind;
         err_q       <= err_q | dec_kind.bad;
      end
   end

   assign at_end = run_q & ~full_q & (beat_q == mask_q);

   // Burst state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         base_q <= '0;
         beat_q <= '0;
         mask_q <= '0;
         full_q <= 1'b0;
         ilv_q  <= 1'b0;
      end else if (start) begin
         run_q  <= 1'b1;
         base_q <= start_col;
         beat_q <= '0;
         mask_q <= mode_mask_q;
         full_q <= mode_kind_q.full;
         ilv_q  <= mode_kind_q.ilv;
      end else if (run_q) begin
         if (stop || at_end) begin
            run_q <= 1'b0;
         end else begin
            beat_q <= beat_q + 1'b1;   // wraps with the page in full-page mode
         end
      end
   end

   burst_addr_gen #(.COL_W(COL_W)) u_gen (
      .base      (base_q),
      .beat      (beat_q),
      .span_mask (mask_q),
      .ilv       (ilv_q),
      .col       (gen_col)
   );

   assign col_out   = run_q ? gen_col : '0;
   assign col_valid = run_q;
   assign col_last  = at_end;
   assign mode_err  = err_q;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
   parameter int COL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [COL_W-1:0] start_col,
   input logic             stop,
   input logic [COL_W-1:0] col_out,
   input logic             col_valid,
   input logic             col_last,
   input logic             mode_err
);
   p_first_beat_r12: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (col_valid && col_out == $past(start_col)));

   p_stop_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start && col_valid) |=> !col_valid);

   p_end_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (col_last && !start) |=> !col_valid);

   p_last_has_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      col_last |-> col_valid);

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |=> mode_err);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !col_valid |-> (col_out == '0 && !col_last));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .start_col (start_col),
   .stop      (stop),
   .col_out   (col_out),
   .col_valid (col_valid),
   .col_last  (col_last),
   .mode_err  (mode_err)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_load = 1'b0;
   logic [3:0]    mode_bits = '0;
   logic          start = 1'b0;
   logic [CW-1:0] start_col = '0;
   logic          stop = 1'b0;
   logic [CW-1:0] col_out;
   logic          col_valid;
   logic          col_last;
   logic          mode_err;

   int n_run = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   burst_col_seq #(.X16_ORG(1'b1)) u_burst_col_seq (
      .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_bits(mode_bits),
      .start(start), .start_col(start_col), .stop(stop),
      .col_out(col_out), .col_valid(col_valid), .col_last(col_last),
      .mode_err(mode_err)
   );

   // {mode[3:0], start[7:0], beats[3:0], expected columns beat0..beat7}
   localparam logic [79:0] VEC [0:8] = '{
      {4'b0011, 8'h25, 4'd8, 64'h25_26_27_20_21_22_23_24},  // R2 seq 8
      {4'b1011, 8'h25, 4'd8, 64'h25_24_27_26_21_20_23_22},  // R3 ilv 8
      {4'b0010, 8'h4E, 4'd4, 64'h4E_4F_4C_4D_00_00_00_00},  // R2 seq 4
      {4'b1010, 8'h4F, 4'd4, 64'h4F_4E_4D_4C_00_00_00_00},  // R3 ilv 4
      {4'b0001, 8'h81, 4'd2, 64'h81_80_00_00_00_00_00_00},  // R4 seq 2
      {4'b1001, 8'h80, 4'd2, 64'h80_81_00_00_00_00_00_00},  // R4 ilv 2
      {4'b0000, 8'h33, 4'd1, 64'h33_00_00_00_00_00_00_00},  // R1 len 1
      {4'b0100, 8'h12, 4'd1, 64'h12_00_00_00_00_00_00_00},  // R8 reserved
      {4'b1110, 8'h07, 4'd1, 64'h07_00_00_00_00_00_00_00}   // R8 reserved
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic load_mode(input logic [3:0] m);
      @(negedge clk);
      mode_load = 1'b1; mode_bits = m;
      @(negedge clk);
      mode_load = 1'b0;
   endtask

   // Pulse start; on return the first beat is on the outputs
   task automatic kick(input logic [CW-1:0] c);
      start = 1'b1; start_col = c;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check(col_valid == 0 && col_last == 0 && col_out == 0, "R11 reset outputs", int'(col_valid), 0);
      check(mode_err == 0, "R11 reset err", int'(mode_err), 0);
      rst_n = 1'b1;

      // Table walk: R1 R2 R3 R4 R5 R8 R12
      foreach (VEC[v]) begin
         load_mode(VEC[v][79:76]);
         kick(VEC[v][75:68]);
         for (int i = 0; i < int'(VEC[v][67:64]); i++) begin
            logic [7:0] e;
            e = VEC[v][63-8*i -: 8];
            check(col_valid && col_out == e, "R2/R3/R4 beat column", int'(col_out), int'(e));
            check(col_last == (i == int'(VEC[v][67:64]) - 1), "R5 last flag", int'(col_last),
                  int'(i == int'(VEC[v][67:64]) - 1));
            @(negedge clk);
         end
         check(!col_valid && col_out == 0, "R5 burst length end", int'(col_valid), 0);
      end

      // R6 full page wraps at 256 and keeps running
      load_mode(4'b0111);
      kick(8'hFE);
      for (int i = 0; i < 4; i++) begin
         logic [7:0] e;
         e = 8'(8'hFE + i);
         check(col_valid && col_out == e && !col_last, "R6 page wrap", int'(col_out), int'(e));
         @(negedge clk);
      end
      repeat (300) @(negedge clk);
      check(col_valid == 1'b1, "R6 no auto end", int'(col_valid), 1);
      // R9 stop ends it on the next clock
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      check(col_valid == 1'b0, "R9 stop full page", int'(col_valid), 0);

      // R7 full page + interleaved falls back to sequential, sticky error
      load_mode(4'b1111);
      check(mode_err == 1'b1, "R7 err set", int'(mode_err), 1);
      kick(8'h05);
      check(col_out == 8'h05, "R7 fallback beat0", int'(col_out), 8'h05);
      @(negedge clk);
      check(col_out == 8'h06, "R7 fallback seq", int'(col_out), 8'h06);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      load_mode(4'b0011);
      check(mode_err == 1'b1, "R7 err sticky", int'(mode_err), 1);

      // R9 stop in the middle of a length-8 burst
      kick(8'h10);
      @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      check(col_valid == 1'b0, "R9 stop mid burst", int'(col_valid), 0);

      // R10 restart during a burst
      kick(8'h10);
      @(negedge clk);
      kick(8'h46);
      for (int i = 0; i < 8; i++) begin
         logic [7:0] e;
         e = {5'b01000, 3'(3'd6 + i)};
         check(col_valid && col_out == e, "R10 restart order", int'(col_out), int'(e));
         @(negedge clk);
      end
      check(col_valid == 1'b0, "R10 restart length", int'(col_valid), 0);

      // R1 mode loaded on the start edge is not used by that burst
      load_mode(4'b0000);
      mode_load = 1'b1; mode_bits = 4'b0011;
      kick(8'h20);
      mode_load = 1'b0;
      @(negedge clk);
      check(col_valid == 1'b0, "R1 old mode used", int'(col_valid), 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule